// File: doc/BRIEF.md
# GPIO Port Configuration and Edge Interrupt Front End

This block sits between the pads of five general-purpose I/O ports and the interrupt controller. For every pin it holds an output value and a two-bit pin mode, and from these it produces the pad output enable, the pad drive value and the pull-up request. On the first two ports each pin has its own mode. On the remaining three ports a single mode register applies to every pin of the port.

Each pin input passes through a two-stage synchronizer and then an edge detector. A per-pin polarity bit selects whether the pin responds to rising or falling edges. A detected edge sets a sticky pending bit, which software clears by writing 1 to it. Enabled pending bits are ORed into one request per port. Port 0 pins 2, 3 and 4 each have a dedicated request line and are left out of the Port 0 request. All configuration goes through a single write-only register port, and pending state is seen only through the request lines.

Top module: `gpio_irq_front`

## Requirements
- R1: After reset every pin is a high-impedance input (pad_oe, pad_out and pad_pu all 0), all output values, enables and polarities are 0, and no request line is high.
- R2: Pin mode code {hi,lo}: 00 = high-impedance input (oe 0, pu 0); 01 = input with pull-up (oe 0, pu 1); 10 = open-drain; 11 = push-pull (oe 1, pad_out = output value bit). pad_out is 0 whenever oe is 0.
- R3: On Ports 0 and 1, register kind 1 holds the low mode bit and kind 2 the high mode bit of each pin, one bit per pin position. On Ports 2, 3 and 4, a kind 1 write takes wr_data[1:0] as {hi,lo} for every pin of the port, and kind 2 writes have no effect.
- R4: In open-drain mode a pin with output value 0 is driven low (oe 1, pad_out 0), and a pin with output value 1 is released (oe 0, pad_out 0, pu 0).
- R5: With polarity bit 1 a rising edge, and with polarity bit 0 a falling edge, sets the pin's pending bit. The pin input passes two synchronizer flops, so the pending bit (and an enabled request) becomes visible right after the third rising clock edge after the input changed, not earlier. Edges of the other direction set nothing.
- R6: A pending bit stays set until software clears it. A request line that is high stays high on every cycle that follows a cycle with no register write.
- R7: A kind 5 write clears each pending bit of the port where wr_data has a 1. When a qualifying edge is detected in the same cycle as the clear, the bit stays set.
- R8: A port request equals the OR over its pins of pending AND enable (kind 3, bit per pin). Pending bits still capture edges while disabled, so a pin's request appears once its enable is written to 1.
- R9: irq_pin[i] equals pending AND enable of Port 0 pin 2+i, for i = 0..2. These three pins never contribute to irq_port[0].
- R10: wr_addr = {port[5:3], kind[2:0]}. Kinds are 0 output value, 1 and 2 mode, 3 enable, 4 polarity (1 = rising), 5 clear. Writes to kinds 6 and 7 or to port numbers 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address: port number in bits 5:3, register kind in bits 2:0 |
| wr_data | input | 8 | Write data, one bit per pin position |
| pin_in | input | 40 | Asynchronous pin inputs, port p in bits 8p+7 to 8p |
| pad_oe | output | 40 | Pad output enable per pin |
| pad_out | output | 40 | Pad drive value per pin |
| pad_pu | output | 40 | Pad pull-up request per pin |
| irq_port | output | 5 | One interrupt request per port |
| irq_pin | output | 3 | Dedicated requests for Port 0 pins 2 to 4 |

## Verification
On every cycle, the assertions check that the pad controls never combine a pull-up or a high drive value with a driven state they do not belong to. They also check that a raised request survives every cycle that follows a cycle with no write, and that a port request never rises unless a write or an input change three cycles earlier caused it. Only the bench scenarios can show the exact latency of the synchronizer, the correct choice of edge direction, the same-cycle clear and edge ordering, the split between per-pin and port-wide modes, the exclusion of the dedicated pins from the Port 0 request, and that writes to unused addresses are ignored.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int KIND_W = 3;

   localparam logic [KIND_W-1:0] RK_OUT     = 3'd0;
   localparam logic [KIND_W-1:0] RK_MODE_LO = 3'd1;
   localparam logic [KIND_W-1:0] RK_MODE_HI = 3'd2;
   localparam logic [KIND_W-1:0] RK_IEN     = 3'd3;
   localparam logic [KIND_W-1:0] RK_POL     = 3'd4;
   localparam logic [KIND_W-1:0] RK_CLR     = 3'd5;

   typedef enum logic [1:0] {
      PM_HIZ        = 2'b00,
      PM_PULLUP     = 2'b01,
      PM_OPEN_DRAIN = 2'b10,
      PM_PUSH_PULL  = 2'b11
   } pin_mode_e;

   typedef struct packed {
      logic oe;
      logic out;
      logic pu;
   } pad_ctl_t;

   function automatic pad_ctl_t pad_decode(pin_mode_e m, logic d);
      pad_ctl_t c;
      c = '0;
      case (m)
         PM_HIZ:        c = '0;
         PM_PULLUP:     c.pu = 1'b1;
         PM_OPEN_DRAIN: c.oe = ~d;
         PM_PUSH_PULL:  begin
            c.oe  = 1'b1;
            c.out = d;
         end
         default:       c = '0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/gpio_port_cfg.sv
module gpio_port_cfg
   import gpio_irq_pkg::*;
#(
   parameter int PIN_W   = 8,
   parameter bit PER_PIN = 1'b1,
   parameter int PORT_ID = 0,
   parameter int PORT_AW = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [PORT_AW-1:0] wr_port,
   input  logic [KIND_W-1:0]  wr_kind,
   input  logic [PIN_W-1:0]   wr_data,
   output logic [PIN_W-1:0]   dout_o,
   output logic [PIN_W-1:0]   mode_lo_o,
   output logic [PIN_W-1:0]   mode_hi_o,
   output logic [PIN_W-1:0]   ien_o,
   output logic [PIN_W-1:0]   pol_o,
   output logic [PIN_W-1:0]   clr_o
);

   logic sel;
   assign sel = wr_en && (wr_port == PORT_AW'(PORT_ID));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout_o <= '0;
         ien_o  <= '0;
         pol_o  <= '0;
      end else if (sel) begin
         case (wr_kind)
            RK_OUT:  dout_o <= wr_data;
            RK_IEN:  ien_o  <= wr_data;
            RK_POL:  pol_o  <= wr_data;
            default: ;
         endcase
      end
   end

   if (PER_PIN) begin : g_per_pin
      logic [PIN_W-1:0] lo_q, hi_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
         end else if (sel) begin
            if (wr_kind == RK_MODE_LO) lo_q <= wr_data;
            if (wr_kind == RK_MODE_HI) hi_q <= wr_data;
         end
      end
      assign mode_lo_o = lo_q;
      assign mode_hi_o = hi_q;
   end else begin : g_group
      logic [1:0] grp_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            grp_q <= '0;
         else if (sel && wr_kind == RK_MODE_LO)
            grp_q <= wr_data[1:0];
      end
      assign mode_lo_o = {PIN_W{grp_q[0]}};
      assign mode_hi_o = {PIN_W{grp_q[1]}};
   end

   assign clr_o = (sel && wr_kind == RK_CLR) ? wr_data : '0;

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin_i,
   output logic [W-1:0] rise_o,
   output logic [W-1:0] fall_o
);

   logic [W-1:0] meta_q, sync_q, last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         meta_q <= '0;
         sync_q <= '0;
         last_q <= '0;
      end else begin
         meta_q <= pin_i;
         sync_q <= meta_q;
         last_q <= sync_q;
      end
   end

   assign rise_o = sync_q & ~last_q;
   assign fall_o = ~sync_q & last_q;

endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
   import gpio_irq_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] mode_lo_i,
   input  logic [W-1:0] mode_hi_i,
   input  logic [W-1:0] dout_i,
   output logic [W-1:0] oe_o,
   output logic [W-1:0] out_o,
   output logic [W-1:0] pu_o
);

   for (genvar b = 0; b < W; b++) begin : g_pin
      pad_ctl_t c;
      assign c       = pad_decode(pin_mode_e'({mode_hi_i[b], mode_lo_i[b]}), dout_i[b]);
      assign oe_o[b]  = c.oe;
      assign out_o[b] = c.out;
      assign pu_o[b]  = c.pu;
   end

endmodule

// File: rtl/gpio_irq_pend.sv
module gpio_irq_pend #(
   parameter int W       = 8,
   parameter bit HAS_DED = 1'b0,
   parameter int DED_LO  = 2,
   parameter int DED_N   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     rise_i,
   input  logic [W-1:0]     fall_i,
   input  logic [W-1:0]     pol_i,
   input  logic [W-1:0]     ien_i,
   input  logic [W-1:0]     clr_i,
   output logic             req_o,
   output logic [DED_N-1:0] ded_o
);

   localparam logic [W-1:0] DED_MASK =
      HAS_DED ? (W'((1 << DED_N) - 1) << DED_LO) : '0;

   logic [W-1:0] pend_q, hit, act;

   assign hit = (rise_i & pol_i) | (fall_i & ~pol_i);

   always_ff @(posedge clk) begin
      if (!rst_n)
         pend_q <= '0;
      else
         pend_q <= (pend_q & ~clr_i) | hit;
   end

   assign act   = pend_q & ien_i;
   assign req_o = |(act & ~DED_MASK);

   if (HAS_DED) begin : g_ded
      assign ded_o = act[DED_LO +: DED_N];
   end else begin : g_no_ded
      assign ded_o = '0;
   end

endmodule

// File: rtl/gpio_irq_front.sv
module gpio_irq_front
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PORTS     = 5,
   parameter int PIN_W         = 8,
   parameter int PER_PIN_PORTS = 2,
   parameter int DED_LO        = 2,
   parameter int DED_N         = 3,
   localparam int PORT_AW      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int ADDR_W       = PORT_AW + KIND_W,
   localparam int NPINS        = NUM_PORTS * PIN_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [PIN_W-1:0]     wr_data,
   input  logic [NPINS-1:0]     pin_in,
   output logic [NPINS-1:0]     pad_oe,
   output logic [NPINS-1:0]     pad_out,
   output logic [NPINS-1:0]     pad_pu,
   output logic [NUM_PORTS-1:0] irq_port,
   output logic [DED_N-1:0]     irq_pin
);

   if (PIN_W < 2) begin : g_err_width
      $error("PIN_W must be at least 2 to hold a port-wide mode");
   end
   if (PER_PIN_PORTS > NUM_PORTS) begin : g_err_perpin
      $error("PER_PIN_PORTS exceeds NUM_PORTS");
   end
   if (DED_N < 1 || DED_LO + DED_N > PIN_W) begin : g_err_ded
      $error("dedicated pin range does not fit in a port");
   end

   logic [PORT_AW-1:0] wr_port;
   logic [KIND_W-1:0]  wr_kind;
   logic [DED_N-1:0]   ded [NUM_PORTS];

   assign wr_port = wr_addr[ADDR_W-1:KIND_W];
   assign wr_kind = wr_addr[KIND_W-1:0];

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic [PIN_W-1:0] dout, mlo, mhi, ien, pol, clr, rise, fall;

      gpio_port_cfg #(
         .PIN_W   (PIN_W),
         .PER_PIN (p < PER_PIN_PORTS),
         .PORT_ID (p),
         .PORT_AW (PORT_AW)
      ) u_cfg (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (wr_en),
         .wr_port   (wr_port),
         .wr_kind   (wr_kind),
         .wr_data   (wr_data),
         .dout_o    (dout),
         .mode_lo_o (mlo),
         .mode_hi_o (mhi),
         .ien_o     (ien),
         .pol_o     (pol),
         .clr_o     (clr)
      );

      gpio_pin_sync #(.W(PIN_W)) u_sync (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_i  (pin_in[p*PIN_W +: PIN_W]),
         .rise_o (rise),
         .fall_o (fall)
      );

      gpio_pad_ctl #(.W(PIN_W)) u_pad (
         .mode_lo_i (mlo),
         .mode_hi_i (mhi),
         .dout_i    (dout),
         .oe_o      (pad_oe[p*PIN_W +: PIN_W]),
         .out_o     (pad_out[p*PIN_W +: PIN_W]),
         .pu_o      (pad_pu[p*PIN_W +: PIN_W])
      );

      gpio_irq_pend #(
         .W       (PIN_W),
         .HAS_DED (p == 0),
         .DED_LO  (DED_LO),
         .DED_N   (DED_N)
      ) u_pend (
         .clk    (clk),
         .rst_n  (rst_n),
         .rise_i (rise),
         .fall_i (fall),
         .pol_i  (pol),
         .ien_i  (ien),
         .clr_i  (clr),
         .req_o  (irq_port[p]),
         .ded_o  (ded[p])
      );
   end

   always_comb begin
      irq_pin = '0;
      for (int p = 0; p < NUM_PORTS; p++)
         irq_pin = irq_pin | ded[p];
   end

endmodule

// File: rtl/gpio_irq_front_chk.sv
module gpio_irq_front_chk #(
   parameter int NUM_PORTS = 5,
   parameter int PIN_W     = 8,
   parameter int DED_N     = 3,
   localparam int NPINS    = NUM_PORTS * PIN_W
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_en,
   input logic [NPINS-1:0]     pin_in,
   input logic [NPINS-1:0]     pad_oe,
   input logic [NPINS-1:0]     pad_out,
   input logic [NPINS-1:0]     pad_pu,
   input logic [NUM_PORTS-1:0] irq_port,
   input logic [DED_N-1:0]     irq_pin
);

   // R2: a pull-up is only requested on an undriven pin
   p_pu_undriven_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu & pad_oe) == '0);

   // R4: a released or input pin never shows a high drive value
   p_out_low_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_out & ~pad_oe) == '0);

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
      // R6: a raised port request survives a cycle without writes
      p_port_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(irq_port[p]) && !$past(wr_en)) |-> irq_port[p]);

      // R5: a port request rises only after a write or a pin change three cycles back
      p_port_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(irq_port[p]) && !$past(wr_en)) |->
            ($past(pin_in[p*PIN_W +: PIN_W], 3) != $past(pin_in[p*PIN_W +: PIN_W], 4)));
   end

   for (genvar i = 0; i < DED_N; i++) begin : g_ded_chk
      // R6: a raised dedicated request survives a cycle without writes
      p_pin_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(irq_pin[i]) && !$past(wr_en)) |-> irq_pin[i]);
   end

endmodule

bind gpio_irq_front gpio_irq_front_chk #(
   .NUM_PORTS (NUM_PORTS),
   .PIN_W     (PIN_W),
   .DED_N     (DED_N)
) chk_i (.*);

// File: tb/gpio_irq_front_tb_top.sv
module gpio_irq_front_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NP  = 5;
   localparam int PW  = 8;
   localparam int NPN = NP * PW;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0;
   logic [5:0]     wr_addr = '0;
   logic [7:0]     wr_data = '0;
   logic [NPN-1:0] pin_in = '0;
   logic [NPN-1:0] pad_oe, pad_out, pad_pu;
   logic [NP-1:0]  irq_port;
   logic [2:0]     irq_pin;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_irq_front dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .pin_in   (pin_in),
      .pad_oe   (pad_oe),
      .pad_out  (pad_out),
      .pad_pu   (pad_pu),
      .irq_port (irq_port),
      .irq_pin  (irq_pin)
   );

   int    n_vec = 0;
   int    n_bad = 0;
   string cur_tag = "R1";

   // reference state derived from the requirements
   logic [7:0] mo [NP], ml [NP], mh [NP], mi [NP], mp [NP], mpend [NP];
   logic [7:0] s1 [NP], s2 [NP], s3 [NP];

   function automatic logic [5:0] ad(int p, int k);
      return {3'(p), 3'(k)};
   endfunction

   function automatic logic [3*NPN-1:0] exp_pads();
      logic [NPN-1:0] oe, ou, pu;
      oe = '0; ou = '0; pu = '0;
      for (int p = 0; p < NP; p++)
         for (int b = 0; b < PW; b++) begin
            case ({mh[p][b], ml[p][b]})
               2'b01: pu[p*PW+b] = 1'b1;
               2'b10: oe[p*PW+b] = ~mo[p][b];
               2'b11: begin
                  oe[p*PW+b] = 1'b1;
                  ou[p*PW+b] = mo[p][b];
               end
               default: ;
            endcase
         end
      return {oe, ou, pu};
   endfunction

   function automatic logic [7:0] exp_irq();
      logic [4:0] rp;
      logic [2:0] rd;
      for (int p = 0; p < NP; p++)
         rp[p] = |(mpend[p] & mi[p] & ((p == 0) ? 8'b1110_0011 : 8'hFF));
      for (int i = 0; i < 3; i++)
         rd[i] = mpend[0][2+i] & mi[0][2+i];
      return {rd, rp};
   endfunction

   task automatic model_reset();
      for (int p = 0; p < NP; p++) begin
         mo[p] = '0; ml[p] = '0; mh[p] = '0; mi[p] = '0; mp[p] = '0;
         mpend[p] = '0; s1[p] = '0; s2[p] = '0; s3[p] = '0;
      end
   endtask

   task automatic model_edge(logic we, logic [5:0] a, logic [7:0] d, logic [NPN-1:0] pins);
      int pp, kk;
      pp = int'(a[5:3]);
      kk = int'(a[2:0]);
      for (int p = 0; p < NP; p++) begin
         logic [7:0] hit, clr;
         hit = ((s2[p] & ~s3[p]) & mp[p]) | ((~s2[p] & s3[p]) & ~mp[p]);
         clr = (we && pp == p && kk == 5) ? d : 8'h00;
         mpend[p] = (mpend[p] & ~clr) | hit;
      end
      if (we && pp < NP) begin
         case (kk)
            0: mo[pp] = d;
            1: if (pp < 2) ml[pp] = d;
               else begin
                  ml[pp] = {8{d[0]}};
                  mh[pp] = {8{d[1]}};
               end
            2: if (pp < 2) mh[pp] = d;
            3: mi[pp] = d;
            4: mp[pp] = d;
            default: ;
         endcase
      end
      for (int p = 0; p < NP; p++) begin
         s3[p] = s2[p];
         s2[p] = s1[p];
         s1[p] = pins[p*PW +: PW];
      end
   endtask

   task automatic compare();
      logic [3*NPN-1:0] ep;
      logic [7:0]       ei;
      ep = exp_pads();
      ei = exp_irq();
      n_vec++;
      if ({pad_oe, pad_out, pad_pu} !== ep) begin
         n_bad++;
         $display("FAIL %s pads: actual %h expected %h", cur_tag,
                  {pad_oe, pad_out, pad_pu}, ep);
      end
      n_vec++;
      if ({irq_pin, irq_port} !== ei) begin
         n_bad++;
         $display("FAIL %s irq {pin,port}: actual %b expected %b", cur_tag,
                  {irq_pin, irq_port}, ei);
      end
   endtask

   // called at a falling edge; returns at the next falling edge after comparing
   task automatic cycle(logic we, logic [5:0] a, logic [7:0] d);
      wr_en   = we;
      wr_addr = a;
      wr_data = d;
      @(posedge clk);
      model_edge(we, a, d, pin_in);
      @(negedge clk);
      wr_en = 1'b0;
      compare();
   endtask

   task automatic wr(int p, int k, logic [7:0] d);
      cycle(1'b1, ad(p, k), d);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cycle(1'b0, 6'd0, 8'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'd20240611);
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      cur_tag = "R1";
      compare();
      idle(2);

      // R2 / R3: all four modes on Port 0, port-wide mode on Port 2
      cur_tag = "R2";
      wr(0, 1, 8'b1010_1010);
      wr(0, 2, 8'b1100_1100);
      wr(0, 0, 8'b0000_1111);
      wr(0, 0, 8'b1111_0000);
      cur_tag = "R3";
      wr(2, 0, 8'h5A);
      wr(2, 1, 8'h03);
      wr(2, 1, 8'hFD);
      wr(3, 2, 8'hFF);
      wr(1, 2, 8'h0F);
      wr(1, 1, 8'h33);

      // R4: open-drain on Port 1
      cur_tag = "R4";
      wr(1, 1, 8'h00);
      wr(1, 2, 8'hFF);
      wr(1, 0, 8'h55);
      wr(1, 0, 8'hAA);

      // R10: unused kinds and ports ignored
      cur_tag = "R10";
      wr(0, 6, 8'hFF);
      wr(2, 7, 8'hFF);
      wr(5, 0, 8'hFF);
      wr(6, 3, 8'hFF);
      wr(7, 1, 8'hFF);
      idle(1);

      // R5: polarity per pin on Port 3
      cur_tag = "R5";
      wr(3, 3, 8'hFF);
      wr(3, 4, 8'h0F);
      pin_in[24 +: 8] = 8'hF0;
      idle(5);
      pin_in[24 +: 8] = 8'hFF;
      idle(1);
      idle(1);
      idle(2);
      wr(3, 5, 8'hFF);
      pin_in[24 +: 8] = 8'h00;
      idle(5);

      // R6: request holds without writes
      cur_tag = "R6";
      idle(10);
      wr(3, 5, 8'hF0);
      idle(2);

      // R7: clear in the same cycle as a new edge
      cur_tag = "R7";
      wr(2, 3, 8'h01);
      wr(2, 4, 8'h01);
      pin_in[16] = 1'b1;
      idle(5);
      pin_in[16] = 1'b0;
      idle(4);
      pin_in[16] = 1'b1;
      idle(1);
      wr(2, 5, 8'h01);
      idle(2);
      wr(2, 5, 8'h01);
      idle(2);

      // R8: pending captured while masked
      cur_tag = "R8";
      wr(4, 4, 8'hFF);
      pin_in[32 +: 8] = 8'h81;
      idle(6);
      wr(4, 3, 8'h01);
      idle(2);
      wr(4, 3, 8'h80);
      wr(4, 5, 8'h80);
      idle(2);

      // R9: dedicated lines on Port 0
      cur_tag = "R9";
      wr(0, 1, 8'h00);
      wr(0, 2, 8'h00);
      wr(0, 3, 8'hFF);
      wr(0, 4, 8'hFF);
      pin_in[3] = 1'b1;
      idle(5);
      pin_in[4] = 1'b1;
      pin_in[2] = 1'b1;
      idle(5);
      pin_in[0] = 1'b1;
      idle(5);
      wr(0, 5, 8'h08);
      wr(0, 5, 8'h01);
      idle(2);

      // R8: constrained random mix of writes and pin activity
      cur_tag = "R8";
      for (int n = 0; n < 3000; n++) begin
         logic [NPN-1:0] flip;
         flip = {$urandom(), $urandom()} & {$urandom(), $urandom()} & {$urandom(), $urandom()};
         if ($urandom_range(0, 2) == 0) pin_in = pin_in ^ flip;
         if ($urandom_range(0, 3) == 0)
            cycle(1'b1, 6'($urandom_range(0, 63)), 8'($urandom()));
         else
            cycle(1'b0, 6'd0, 8'd0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule